// File: doc/BRIEF.md
# Input Pulse-Width Capture Channel

This timer channel measures how long a pulse on an external pin lasts. The pin is first brought into the clock domain, and its changes are then detected. When the channel is enabled by a specific mode code, it copies the value of a shared counter bus into a start register on the edge that opens a pulse. It copies the counter bus into an end register on the edge that closes the same pulse. Software subtracts the two values to get the width. A single polarity input chooses whether high pulses or low pulses are measured.

The two captures strictly alternate. After a start capture, only a closing edge is accepted, and after that only an opening edge. A closing edge that arrives while the channel waits for an opening edge is dropped. Because of this, a measurement never begins in the middle of a pulse. The end capture raises a sticky completion flag, which is cleared by a one-cycle clear strobe.

A small state machine controls the sequence. Its states are:
- **ST_IDLE**: the mode is off.
- **ST_WAIT_LEAD**: armed, waiting for an opening edge.
- **ST_WAIT_TRAIL**: the start has been captured, waiting for the closing edge.

Its transitions are:
- **enter**: ST_IDLE to ST_WAIT_LEAD, when the mode code matches.
- **lead_hit**: ST_WAIT_LEAD to ST_WAIT_TRAIL, on an opening edge. It captures the start.
- **trail_hit**: ST_WAIT_TRAIL to ST_WAIT_LEAD, on a closing edge. It captures the end and sets the flag.
- **leave**: any state to ST_IDLE, when the mode code stops matching.

Top module: `pwcap_channel`

## Requirements
- R1: After reset, `lead_val` and `trail_val` are 0 and `done_flag` is 0.
- R2: While `mode_sel` is not 7'b0000100, pin edges change neither capture register nor `done_flag`.
- R3: With `pol_pos`=1, a rising pin edge loads `cnt_bus` into `lead_val`, and the following falling edge loads `cnt_bus` into `trail_val`.
- R4: With `pol_pos`=0, a falling pin edge loads `lead_val`, and the following rising edge loads `trail_val`.
- R5: A closing-type edge that arrives while no opening edge has been captured is ignored. Both registers and the flag keep their values.
- R6: Captures alternate. An end capture leaves `lead_val` unchanged, and a start capture leaves `trail_val` unchanged.
- R7: `done_flag` rises with the end capture. A pin change sampled at clock edge k updates the register at edge k+2, together with the flag.
- R8: A one-cycle `flag_clr` clears `done_flag` at the next edge. If an end capture happens in the same cycle, the set wins.
- R9: Leaving the mode drops any half-finished measurement. After re-entry, a closing edge is ignored, and the next opening edge loads `lead_val`.
- R10: A start capture does not change `done_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous pulse input |
| cnt_bus | input | 24 | Selected time-base counter value |
| mode_sel | input | 7 | Channel mode code; 7'b0000100 enables pulse capture |
| pol_pos | input | 1 | 1: measure high pulses; 0: measure low pulses |
| flag_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| lead_val | output | 24 | Counter value latched at the opening edge |
| trail_val | output | 24 | Counter value latched at the closing edge |
| done_flag | output | 1 | Sticky completion flag, set on the closing capture |

## Verification
A state machine stuck in the wrong wait state shows up on the first pulse that follows. The wrong register is loaded, or `done_flag` rises on the opening edge instead of the closing edge, two clocks after the pin change is sampled. A tracking state that is not reset on mode exit only becomes visible after re-entry, when a closing edge loads `trail_val` where it should have been dropped. Polarity errors swap the roles of the two registers on the first measured pulse.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_LEAD  = 2'd1,
        ST_WAIT_TRAIL = 2'd2
    } pw_state_e;

endpackage

// File: rtl/pwcap_sync.sv
// Brings the asynchronous pin into the clock domain and flags single-cycle
// rising and falling edges of the synchronized level.
module pwcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pin_in};
            prev_q  <= chain_q[LAST];
        end
    end

    always_comb begin
        rise = chain_q[LAST] & ~prev_q;
        fall = ~chain_q[LAST] & prev_q;
    end

endmodule

// File: rtl/pwcap_fsm.sv
// Sequences opening and closing captures; strict alternation.
module pwcap_fsm
    import pwcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_on,
    input  logic      pol_pos,
    input  logic      rise,
    input  logic      fall,
    output pw_state_e state_q,
    output logic      lead_cap,
    output logic      trail_cap
);

    pw_state_e state_d;
    logic      lead_edge;
    logic      trail_edge;

    // Polarity picks which edge opens a pulse.
    always_comb begin
        lead_edge  = pol_pos ? rise : fall;
        trail_edge = pol_pos ? fall : rise;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!mode_on) begin
            state_d = ST_IDLE;                          // leave
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_WAIT_LEAD;  // enter
                ST_WAIT_LEAD:  if (lead_edge)  state_d = ST_WAIT_TRAIL; // lead_hit
                ST_WAIT_TRAIL: if (trail_edge) state_d = ST_WAIT_LEAD;  // trail_hit
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Output strobes
    always_comb begin
        lead_cap  = 1'b0;
        trail_cap = 1'b0;
        if (mode_on) begin
            unique case (state_q)
                ST_IDLE:       ;
                ST_WAIT_LEAD:  lead_cap  = lead_edge;
                ST_WAIT_TRAIL: trail_cap = trail_edge;
                default:       ;
            endcase
        end
    end

endmodule

// File: rtl/pwcap_regs.sv
// Capture registers and sticky completion flag.
module pwcap_regs #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead_cap,
    input  logic             trail_cap,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] cnt_bus,
    output logic [CNT_W-1:0] lead_val,
    output logic [CNT_W-1:0] trail_val,
    output logic             done_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_val  <= '0;
            trail_val <= '0;
        end else begin
            if (lead_cap)  lead_val  <= cnt_bus;
            if (trail_cap) trail_val <= cnt_bus;
        end
    end

    // Set has priority over clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (trail_cap) begin
            done_flag <= 1'b1;
        end else if (flag_clr) begin
            done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel
    import pwcap_pkg::*;
#(
    parameter int          CNT_W     = 24,
    parameter int          MODE_W    = 7,
    parameter logic [6:0]  MODE_CODE = 7'b0000100,
    parameter int          SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic [CNT_W-1:0]  cnt_bus,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              pol_pos,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  lead_val,
    output logic [CNT_W-1:0]  trail_val,
    output logic              done_flag
);

    logic      mode_on;
    logic      rise;
    logic      fall;
    logic      lead_cap;
    logic      trail_cap;
    pw_state_e state_q;

    assign mode_on = (mode_sel == MODE_W'(MODE_CODE));

    pwcap_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    pwcap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_on   (mode_on),
        .pol_pos   (pol_pos),
        .rise      (rise),
        .fall      (fall),
        .state_q   (state_q),
        .lead_cap  (lead_cap),
        .trail_cap (trail_cap)
    );

    pwcap_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lead_cap  (lead_cap),
        .trail_cap (trail_cap),
        .flag_clr  (flag_clr),
        .cnt_bus   (cnt_bus),
        .lead_val  (lead_val),
        .trail_val (trail_val),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk
    import pwcap_pkg::*;
#(
    parameter int         CNT_W     = 24,
    parameter int         MODE_W    = 7,
    parameter logic [6:0] MODE_CODE = 7'b0000100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_sel,
    input logic              flag_clr,
    input logic [CNT_W-1:0]  lead_val,
    input logic [CNT_W-1:0]  trail_val,
    input logic              done_flag,
    input pw_state_e         state_q,
    input logic              lead_cap,
    input logic              trail_cap
);

    // R2
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != MODE_W'(MODE_CODE)) |=> ($stable(lead_val) && $stable(trail_val)));

    // R6
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_cap |-> (state_q == ST_WAIT_TRAIL && !lead_cap));

    // R6
    trail_keeps_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_cap |=> $stable(lead_val));

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(state_q) == ST_WAIT_TRAIL);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trail_cap) |=> !done_flag);

    // R10
    lead_flag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_cap && !flag_clr) |=> $stable(done_flag));

endmodule

bind pwcap_channel pwcap_chk #(
    .CNT_W     (CNT_W),
    .MODE_W    (MODE_W),
    .MODE_CODE (MODE_CODE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .flag_clr  (flag_clr),
    .lead_val  (lead_val),
    .trail_val (trail_val),
    .done_flag (done_flag),
    .state_q   (state_q),
    .lead_cap  (lead_cap),
    .trail_cap (trail_cap)
);

// File: tb/test_pwcap_channel.sv
module test_pwcap_channel;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] MODE_ON = 7'b0000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [23:0] cnt_bus = '0;
    logic [6:0]  mode_sel = '0;
    logic        pol_pos = 1'b1;
    logic        flag_clr = 1'b0;
    logic [23:0] lead_val;
    logic [23:0] trail_val;
    logic        done_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwcap_channel i_pwcap_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .cnt_bus   (cnt_bus),
        .mode_sel  (mode_sel),
        .pol_pos   (pol_pos),
        .flag_clr  (flag_clr),
        .lead_val  (lead_val),
        .trail_val (trail_val),
        .done_flag (done_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [23:0] el,
                             input logic [23:0] et, input logic ef);
        check(req, "lead_val", lead_val, el);
        check(req, "trail_val", trail_val, et);
        check(req, "done_flag", {23'd0, done_flag}, {23'd0, ef});
    endtask

    // Pin change sampled at edge k; register loads at edge k+2.
    task automatic pin_step(input logic lvl, input logic [23:0] cnt);
        @(negedge clk);
        pin_in  = lvl;
        cnt_bus = cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic set_mode(input logic [6:0] m);
        @(negedge clk);
        mode_sel = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check_all("R1", 24'h0, 24'h0, 1'b0);
    endtask

    task automatic t_mode_off();
        set_mode(7'b0000101);
        pol_pos = 1'b1;
        pin_step(1'b1, 24'h000111);
        pin_step(1'b0, 24'h000222);
        check_all("R2", 24'h0, 24'h0, 1'b0);
    endtask

    task automatic t_positive();
        set_mode(MODE_ON);
        pin_step(1'b1, 24'h000100);
        check_all("R3", 24'h000100, 24'h0, 1'b0);   // R10: flag stays low
        check("R10", "done_flag", {23'd0, done_flag}, 24'h0);
        pin_step(1'b0, 24'h000180);
        check_all("R3", 24'h000100, 24'h000180, 1'b1);
        check("R6", "lead_val", lead_val, 24'h000100);
        check("R7", "done_flag", {23'd0, done_flag}, 24'h1);
    endtask

    task automatic t_clear();
        pulse_clr();
        check("R8", "done_flag after clear", {23'd0, done_flag}, 24'h0);
        pin_step(1'b1, 24'h000200);
        // closing edge with clear in the capture cycle: set wins
        @(negedge clk);
        pin_in  = 1'b0;
        cnt_bus = 24'h000260;
        repeat (2) @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "set wins", {23'd0, done_flag}, 24'h1);
        check("R7", "trail_val", trail_val, 24'h000260);
        pulse_clr();
    endtask

    task automatic t_negative();
        pol_pos = 1'b0;
        @(negedge clk);
        // rising edge is closing-type while waiting for opening: ignored
        pin_step(1'b1, 24'h000300);
        check_all("R5", 24'h000200, 24'h000260, 1'b0);
        pin_step(1'b0, 24'h000400);
        check_all("R4", 24'h000400, 24'h000260, 1'b0);
        pin_step(1'b1, 24'h000480);
        check_all("R4", 24'h000400, 24'h000480, 1'b1);
        pulse_clr();
    endtask

    task automatic t_mode_exit();
        pol_pos = 1'b1;
        @(negedge clk);
        pin_step(1'b0, 24'h000500);   // closing-type, ignored
        check_all("R5", 24'h000400, 24'h000480, 1'b0);
        pin_step(1'b1, 24'h000600);
        check_all("R3", 24'h000600, 24'h000480, 1'b0);
        set_mode(7'b0000000);
        set_mode(MODE_ON);
        pin_step(1'b0, 24'h000700);   // dropped after re-entry
        check_all("R9", 24'h000600, 24'h000480, 1'b0);
        pin_step(1'b1, 24'h000800);
        check_all("R9", 24'h000800, 24'h000480, 1'b0);
        pin_step(1'b0, 24'h000880);
        check_all("R9", 24'h000800, 24'h000880, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_off();
        t_positive();
        t_clear();
        t_negative();
        t_mode_exit();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule